// File: doc/BRIEF.md
# ECC Read Response Tracker

This block sits on the read-return path of a memory controller that protects its storage with ECC. The controller hands it each returned read word together with the access address and the two detection flags computed for that access: corrected single-bit error and uncorrectable double-bit error. The tracker stores the word and that access's own error outcome together in one slot of a circular buffer. It then returns the responses to the requesting master strictly in acceptance order, each with a bus status code. The status is always the one captured with that slot's data, even after the slot has been reused many times.

Alongside the response path, a double-bit error raises a raw interrupt status bit whatever the enable setting. An enable bit, driven through separate write-one-to-set and write-one-to-clear registers, gates the raw bit into an enabled status view and onto the interrupt line. The address of the first failing access is kept in a log register until software clears the raw bit. Software reaches these registers through a small select/write/read port.

Top module: `ecc_rd_resp_trk`

## Requirements
- R1: After reset, rsp_valid is 0, in_ready is 1, irq is 0, and every register select (0 to 4) reads 0.
- R2: Accepted words (in_valid and in_ready high at a clock edge) are returned on rsp_data in the same order, one per rsp_valid/rsp_ready handshake, across repeated wraparound of the 32-slot buffer.
- R3: rsp_status is 2'b11 (bus error) when the response's own access had in_db_err set, and 2'b00 (OK) otherwise, independent of the flags of neighbouring slots.
- R4: An access with only in_sb_err set returns status 2'b00 and does not set the raw double-bit status bit.
- R5: An accepted access with in_db_err set makes bit 4 of the raw status register (select 0) read 1 from the next cycle, whether or not the interrupt is enabled.
- R6: Writing a word with bit 4 set to select 2 sets the enable bit and writing it to select 3 clears it; selects 2 and 3 both read the enable in bit 4. Select 1 reads bit 4 as raw AND enable, and irq equals that same value.
- R7: Writing a word with bit 4 set to select 0 clears the raw bit and drops irq; writing 0 there changes nothing.
- R8: Select 4 reads the 32-bit address of the first double-bit error accepted while the raw bit was clear; later errors leave it unchanged until the raw bit is cleared, after which the next error is logged.
- R9: With 32 responses held and none drained, in_ready is 0 and no held slot is overwritten.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_data and rsp_status stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Returned read word offered |
| in_ready | output | 1 | Buffer has a free slot |
| in_addr | input | 32 | Address of the returned access |
| in_data | input | 32 | Returned read word |
| in_sb_err | input | 1 | Corrected single-bit error on this access |
| in_db_err | input | 1 | Uncorrectable double-bit error on this access |
| rsp_valid | output | 1 | Response to master available |
| rsp_ready | input | 1 | Master accepts the response |
| rsp_data | output | 32 | Response data |
| rsp_status | output | 2 | 2'b00 OK, 2'b11 bus error |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| irq | output | 1 | Enabled double-bit error interrupt |

## Verification
The properties assume the controller only raises in_db_err and in_sb_err together with in_valid, and that software never writes a clear in the same cycle as a new double-bit error arrives; the stimulus issues register writes only between traffic phases. The stability property takes for granted that the master keeps rsp_ready low only to stall, which the consumer's fixed stall pattern respects. The error flag patterns use co-prime periods so that error and clean responses sit next to each other in every slot pairing as the buffer wraps four times.

// File: rtl/ecc_trk_pkg.sv
package ecc_trk_pkg;

   typedef enum logic [1:0] {
      RSP_OK     = 2'b00,
      RSP_BUSERR = 2'b11
   } rsp_stat_e;

   localparam logic [2:0] SEL_RAW   = 3'd0;
   localparam logic [2:0] SEL_MSKD  = 3'd1;
   localparam logic [2:0] SEL_ENSET = 3'd2;
   localparam logic [2:0] SEL_ENCLR = 3'd3;
   localparam logic [2:0] SEL_ALOG  = 3'd4;

endpackage

// File: rtl/ecc_trk_ring.sv
module ecc_trk_ring #(
   parameter int DW    = 32,
   parameter int DEPTH = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   output logic          wr_ready,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_err,
   output logic          rd_valid,
   input  logic          rd_ready,
   output logic [DW-1:0] rd_data,
   output logic          rd_err
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("ecc_trk_ring: DEPTH must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ecc_trk_ring: DW must be positive");
   end

   logic [PW:0]   wr_ptr, rd_ptr;
   logic [PW-1:0] wr_idx, rd_idx;
   logic          full, empty, wr_fire, rd_fire;

   logic [DW-1:0] slot_data [DEPTH];
   logic          slot_err  [DEPTH];

   assign wr_idx   = wr_ptr[PW-1:0];
   assign rd_idx   = rd_ptr[PW-1:0];
   assign empty    = (wr_ptr == rd_ptr);
   assign full     = (wr_idx == rd_idx) && (wr_ptr[PW] != rd_ptr[PW]);
   assign wr_ready = !full;
   assign rd_valid = !empty;
   assign wr_fire  = wr_valid && !full;
   assign rd_fire  = rd_ready && !empty;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_data[g] <= '0;
            slot_err[g]  <= 1'b0;
         end else if (wr_fire && (wr_idx == PW'(g))) begin
            slot_data[g] <= wr_data;
            slot_err[g]  <= wr_err;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
         if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   assign rd_data = slot_data[rd_idx];
   assign rd_err  = slot_err[rd_idx];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_ready) |=> (!wr_ready && $stable(wr_ptr))); // R9

   AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_err))); // R10

endmodule

// File: rtl/ecc_trk_regs.sv
module ecc_trk_regs
   import ecc_trk_pkg::*;
#(
   parameter int AW     = 32,
   parameter int RW     = 32,
   parameter int DB_BIT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          err_evt,
   input  logic [AW-1:0] err_addr,
   input  logic          reg_we,
   input  logic [2:0]    reg_sel,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          raw_o,
   output logic          irq
);
   if (DB_BIT >= RW) begin : g_bad_bit
      $error("ecc_trk_regs: DB_BIT outside register width");
   end
   if (AW > RW) begin : g_bad_aw
      $error("ecc_trk_regs: address wider than register port");
   end

   localparam logic [RW-1:0] DB_MASK = RW'(1) << DB_BIT;

   logic          raw_q, en_q;
   logic [AW-1:0] log_q;
   logic          bit_hit, clr_raw, en_set, en_clr;

   assign bit_hit = |(reg_wdata & DB_MASK);
   assign clr_raw = reg_we && (reg_sel == SEL_RAW)   && bit_hit;
   assign en_set  = reg_we && (reg_sel == SEL_ENSET) && bit_hit;
   assign en_clr  = reg_we && (reg_sel == SEL_ENCLR) && bit_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         en_q  <= 1'b0;
         log_q <= '0;
      end else begin
         if (err_evt)      raw_q <= 1'b1;
         else if (clr_raw) raw_q <= 1'b0;
         if (en_set)       en_q  <= 1'b1;
         else if (en_clr)  en_q  <= 1'b0;
         if (err_evt && !raw_q) log_q <= err_addr;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_RAW:   reg_rdata[DB_BIT] = raw_q;
         SEL_MSKD:  reg_rdata[DB_BIT] = raw_q & en_q;
         SEL_ENSET,
         SEL_ENCLR: reg_rdata[DB_BIT] = en_q;
         SEL_ALOG:  reg_rdata[AW-1:0] = log_q;
         default:   reg_rdata = '0;
      endcase
   end

   assign raw_o = raw_q;
   assign irq   = raw_q & en_q;

   AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> raw_o); // R5

   AST_LOG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt && !raw_o) |=> (log_q == $past(err_addr))); // R8

   AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      raw_o |=> $stable(log_q)); // R8

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_raw && !err_evt) |=> !irq); // R7

endmodule

// File: rtl/ecc_rd_resp_trk.sv
module ecc_rd_resp_trk
   import ecc_trk_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 32,
   parameter int RW     = 32,
   parameter int DEPTH  = 32,
   parameter int DB_BIT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   input  logic          in_sb_err,
   input  logic          in_db_err,
   output logic          rsp_valid,
   input  logic          rsp_ready,
   output logic [DW-1:0] rsp_data,
   output logic [1:0]    rsp_status,
   input  logic          reg_we,
   input  logic [2:0]    reg_sel,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          irq
);
   logic in_fire, db_evt, slot_err, db_raw;

   assign in_fire = in_valid && in_ready;
   assign db_evt  = in_fire && in_db_err;

   ecc_trk_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (in_valid),
      .wr_ready (in_ready),
      .wr_data  (in_data),
      .wr_err   (in_db_err),
      .rd_valid (rsp_valid),
      .rd_ready (rsp_ready),
      .rd_data  (rsp_data),
      .rd_err   (slot_err)
   );

   ecc_trk_regs #(.AW(AW), .RW(RW), .DB_BIT(DB_BIT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_evt   (db_evt),
      .err_addr  (in_addr),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .raw_o     (db_raw),
      .irq       (irq)
   );

   assign rsp_status = slot_err ? RSP_BUSERR : RSP_OK;

   AST_SB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && in_sb_err && !in_db_err && !db_raw) |=> !db_raw); // R4

   AST_STAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_status == RSP_OK) || (rsp_status == RSP_BUSERR))); // R3

endmodule

// File: tb/sim_ecc_rd_resp_trk.sv
module sim_ecc_rd_resp_trk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sb_err = 1'b0, in_db_err = 1'b0;
   logic [31:0] in_addr = '0, in_data = '0;
   logic        in_ready, rsp_valid, irq;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_data, reg_rdata;
   logic [1:0]  rsp_status;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   ecc_rd_resp_trk u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_data(in_data), .in_sb_err(in_sb_err), .in_db_err(in_db_err),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_status(rsp_status),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [31:0] e_data(int i);
      return (i * 32'h0001_0003) ^ 32'h5A5A_0000;
   endfunction
   function automatic logic e_db(int i);
      return (i % 7) == 3;
   endfunction
   function automatic logic e_sb(int i);
      return ((i % 5) == 1) && !e_db(i);
   endfunction
   function automatic logic [31:0] e_addr(int i);
      return 32'h0000_1000 + i * 4;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(logic [31:0] d, logic [31:0] a, logic sb, logic db);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_addr = a; in_sb_err = sb; in_db_err = db;
      while (!in_ready) @(negedge clk);
   endtask

   task automatic idle_in();
      @(negedge clk);
      in_valid = 1'b0; in_sb_err = 1'b0; in_db_err = 1'b0;
   endtask

   task automatic push_range(int lo, int hi);
      for (int i = lo; i < hi; i++) begin
         push(e_data(i), e_addr(i), e_sb(i), e_db(i));
         if ((i % 9) == 4) idle_in();
      end
      idle_in();
   endtask

   task automatic pop_range(int lo, int hi);
      int k = lo;
      int cyc = 0;
      logic held = 1'b0;
      logic [31:0] sd = '0;
      logic [1:0]  ss = '0;
      while (k < hi) begin
         @(negedge clk);
         cyc++;
         if (held) begin
            chk("R10 valid held", {31'b0, rsp_valid}, 32'd1);
            chk("R10 data held", rsp_data, sd);
            chk("R10 status held", {30'b0, rsp_status}, {30'b0, ss});
         end
         rsp_ready = ((cyc % 4) != 2) && ((cyc % 11) != 5);
         if (rsp_valid && rsp_ready) begin
            chk("R2 order data", rsp_data, e_data(k));
            chk("R3 slot status", {30'b0, rsp_status}, e_db(k) ? 32'd3 : 32'd0);
            k++;
         end
         held = rsp_valid && !rsp_ready;
         sd = rsp_data; ss = rsp_status;
      end
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   task automatic pop_one(string tag, logic [31:0] d, logic [1:0] st);
      @(negedge clk);
      while (!rsp_valid) @(negedge clk);
      chk({tag, " data"}, rsp_data, d);
      chk({tag, " status"}, {30'b0, rsp_status}, {30'b0, st});
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   task automatic wr(logic [2:0] s, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(logic [2:0] s, output logic [31:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
      chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
      chk("R1 irq", {31'b0, irq}, 32'd0);
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), v);
         chk("R1 register", v, 32'd0);
      end

      // R9 fill all 32 slots with no draining
      push_range(0, 32);
      @(negedge clk);
      chk("R9 in_ready full", {31'b0, in_ready}, 32'd0);
      chk("R9 rsp_valid full", {31'b0, rsp_valid}, 32'd1);
      chk("R9 head intact", rsp_data, e_data(0));
      rd(3'd0, v); chk("R5 raw set while disabled", v, 32'h10);
      rd(3'd1, v); chk("R6 enabled view off", v, 32'h0);
      chk("R6 irq off while disabled", {31'b0, irq}, 32'd0);

      // R2 R3 streaming across several wraps with stalls
      fork
         push_range(32, 128);
         pop_range(0, 128);
      join
      rd(3'd4, v); chk("R8 first address held", v, e_addr(3));

      // R6 enable through set register
      wr(3'd2, 32'h10);
      rd(3'd2, v); chk("R6 enable set read", v, 32'h10);
      rd(3'd3, v); chk("R6 enable clr read", v, 32'h10);
      rd(3'd1, v); chk("R6 enabled view on", v, 32'h10);
      chk("R6 irq on", {31'b0, irq}, 32'd1);

      // R7 writing 0 does nothing, writing bit 4 clears
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk("R7 zero write ignored", v, 32'h10);
      chk("R7 irq kept", {31'b0, irq}, 32'd1);
      wr(3'd0, 32'h10);
      rd(3'd0, v); chk("R7 raw cleared", v, 32'h0);
      chk("R7 irq dropped", {31'b0, irq}, 32'd0);

      // R4 single-bit error only
      push(32'hC0DE_0001, 32'h0000_A000, 1'b1, 1'b0);
      idle_in();
      pop_one("R4 sb response", 32'hC0DE_0001, 2'b00);
      rd(3'd0, v); chk("R4 raw stays clear", v, 32'h0);
      chk("R4 irq stays low", {31'b0, irq}, 32'd0);

      // R8 new first error logged, second one ignored
      push(32'hBAD0_0002, 32'h0000_B004, 1'b0, 1'b1);
      idle_in();
      rd(3'd4, v); chk("R8 new log after clear", v, 32'h0000_B004);
      chk("R6 irq with enable", {31'b0, irq}, 32'd1);
      push(32'hBAD0_0003, 32'h0000_C008, 1'b0, 1'b1);
      idle_in();
      rd(3'd4, v); chk("R8 log keeps first", v, 32'h0000_B004);
      pop_one("R3 db response", 32'hBAD0_0002, 2'b11);
      pop_one("R3 db response 2", 32'hBAD0_0003, 2'b11);

      // R6 clear enable
      wr(3'd3, 32'h10);
      rd(3'd2, v); chk("R6 enable cleared", v, 32'h0);
      chk("R6 irq gated off", {31'b0, irq}, 32'd0);
      rd(3'd0, v); chk("R5 raw kept when disabled", v, 32'h10);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule